// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core in which every instruction fetches, decodes, executes, touches memory and writes back within one clock period. It supports six operations: register add and subtract (both wrap modulo 2^32), OR with a zero-extended immediate, word load, word store, and branch-if-equal. The instruction store and the data store are small word-addressed arrays held inside the block. Both are filled through a preload port before the core is released from reset.

The datapath consists of a program counter, a 32-entry by 32-bit register bank with two combinational read ports, an adder/subtractor/OR unit that also produces an equality flag, an immediate extender, and next-address logic. A per-opcode decoder drives the datapath. Its outputs select the branch, the second operand source, the unit operation, the extension mode, the store strobe, the load-to-register path, the register write and the destination field. Observation outputs show the current PC and the register-bank write strobe, address and data each cycle, so a checker can follow execution.

Reset is asynchronous and active low. Its release is synchronised, so the PC starts stepping from address 0 on the third rising edge after `rst_n` rises.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `dbg_pc` is 0 and `dbg_wr_en` is 0, and this takes effect without waiting for a clock edge. After release, the core waits two rising edges and then executes the word at address 0.
- R2: Opcode 0x00 with shamt 0 writes register rd with rs+rt when funct is 0x21, and with rs-rt when funct is 0x23. Fields: op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0].
- R3: Opcode 0x0D writes register rt with rs OR {16'h0, imm[15:0]}.
- R4: Opcode 0x23 writes register rt with the data word at byte address rs + sign-extended imm. The word index is address bits [MEM_AW+1:2].
- R5: Opcode 0x2B stores rt at the same address form as R4 and does not write the register bank. A load that follows in the next cycle returns the stored value.
- R6: Opcode 0x04 sets the next PC to PC+4+(sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise. It never writes the register bank.
- R7: Register 0 always reads as 0, even after an instruction names it as destination.
- R8: Any other opcode, and opcode 0x00 with an unlisted funct or nonzero shamt, writes nothing and advances the PC by 4.
- R9: The PC advances once per clock cycle while running, and it is always word aligned.
- R10: When `load_en` is high, `load_data` is written at word `load_addr` of the instruction store (`load_sel`=0) or the data store (`load_sel`=1) on the rising edge. This also works while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Preload write strobe |
| load_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| load_addr | input | MEM_AW | Preload word index |
| load_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | Register-bank write strobe this cycle |
| dbg_wr_addr | output | 5 | Register-bank write index this cycle |
| dbg_wr_data | output | 32 | Register-bank write data this cycle |

## Verification
The hardest situation to create from the ports is a register-bank or data-store effect that leaves no direct trace. This covers a store, whose only evidence is a later load, a write aimed at register 0, and a skipped branch shadow. The program therefore stores a sum and then reloads it through two different base/offset pairs, including a negative offset. It then branches on the equality of the two reloads, so a wrong store or a wrong extension moves the PC trace. A write to register 0 is followed by an add that reads register 0 twice, so any leak appears on the write data.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU   = 6'h21;
  localparam logic [5:0] FN_SUBU   = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    branch;
    logic    src_imm;
    alu_op_e alu_op;
    logic    zero_ext;
    logic    mem_we;
    logic    mem_to_reg;
    logic    reg_we;
    logic    dst_rd;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_RTYPE: begin
        if (shamt == '0 && (funct == FN_ADDU || funct == FN_SUBU)) begin
          ctrl.reg_we = 1'b1;
          ctrl.dst_rd = 1'b1;
          ctrl.alu_op = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctrl.src_imm  = 1'b1;
        ctrl.zero_ext = 1'b1;
        ctrl.alu_op   = ALU_OR;
        ctrl.reg_we   = 1'b1;
      end
      OPC_LOAD: begin
        ctrl.src_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_we     = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         eq
);

  always_comb begin
    unique case (op)
      ALU_SUB: res = opa - opb;
      ALU_OR:  res = opa | opb;
      default: res = opa + opb;
    endcase
  end

  assign eq = (opa == opb);

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank #(
  parameter int unsigned W     = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b
);

  logic [W-1:0] regs [NREGS];

  // Entry 0 is never stored; reads of index 0 return zero (R7).
  always_ff @(posedge clk) begin
    if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int unsigned MEM_AW = 6,
  localparam int unsigned MEM_WORDS = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              load_sel,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [XLEN-1:0]   load_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wr_en,
  output logic [4:0]        dbg_wr_addr,
  output logic [XLEN-1:0]   dbg_wr_data
);

  // Reset release synchroniser
  logic [1:0] rel_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= '0;
    else        rel_q <= {rel_q[0], 1'b1};
  end
  assign run = rel_q[1];

  // Storage arrays
  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] instr;
  logic [5:0]      f_op, f_fn;
  logic [4:0]      f_rs, f_rt, f_rd, f_sh;
  logic [15:0]     f_imm;

  assign instr = imem[pc_q[MEM_AW+1:2]];
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  ctrl_t ctrl;
  sc_decode i_dec (
    .opcode (f_op),
    .shamt  (f_sh),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  // Register bank
  logic [XLEN-1:0] rs_val, rt_val, wb_data;
  logic [4:0]      wb_addr;
  logic            wb_en;

  sc_regbank #(.W(XLEN), .NREGS(32)) i_rf (
    .clk  (clk),
    .we   (wb_en),
    .wa   (wb_addr),
    .wd   (wb_data),
    .ra_a (f_rs),
    .rd_a (rs_val),
    .ra_b (f_rt),
    .rd_b (rt_val)
  );

  // Immediate extender and operand select
  logic [XLEN-1:0] imm_ext, opb, alu_res;
  logic            alu_eq;

  assign imm_ext = ctrl.zero_ext ? {16'h0000, f_imm} : {{16{f_imm[15]}}, f_imm};
  assign opb     = ctrl.src_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) i_alu (
    .opa (rs_val),
    .opb (opb),
    .op  (ctrl.alu_op),
    .res (alu_res),
    .eq  (alu_eq)
  );

  // Data store: preload has priority over a core store
  logic [XLEN-1:0] ld_word;
  logic            st_en;

  assign ld_word = dmem[alu_res[MEM_AW+1:2]];
  assign st_en   = run && ctrl.mem_we;

  always_ff @(posedge clk) begin
    if (load_en && load_sel) begin
      dmem[load_addr] <= load_data;
    end else if (st_en) begin
      dmem[alu_res[MEM_AW+1:2]] <= rt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en && !load_sel) begin
      imem[load_addr] <= load_data;
    end
  end

  // Write-back
  assign wb_en   = run && ctrl.reg_we;
  assign wb_addr = ctrl.dst_rd ? f_rd : f_rt;
  assign wb_data = ctrl.mem_to_reg ? ld_word : alu_res;

  // Next-address logic
  logic            taken;
  logic [XLEN-1:0] pc_seq;

  assign taken  = ctrl.branch && alu_eq;
  assign pc_seq = pc_q + 32'd4;

  always_comb begin
    pc_d = pc_seq;
    if (taken) pc_d = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = wb_en;
  assign dbg_wr_addr = wb_addr;
  assign dbg_wr_data = wb_data;

  // Assertions
  a_r1_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc_q == '0));

  a_r9_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);

  a_r6_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !taken) |=> (pc_q == $past(pc_q) + 32'd4));

  a_r5_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !dbg_wr_en);

endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/100ps
module test_sc_core;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en, load_sel;
  logic [AW-1:0] load_addr;
  logic [31:0]   load_data;
  logic [31:0]   dbg_pc, dbg_wr_data;
  logic          dbg_wr_en;
  logic [4:0]    dbg_wr_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sc_core #(.MEM_AW(AW)) i_sc_core (
    .clk, .rst_n, .load_en, .load_sel, .load_addr, .load_data,
    .dbg_pc, .dbg_wr_en, .dbg_wr_addr, .dbg_wr_data
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd,
                                        input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op,
                                        input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  localparam int NPROG = 18;
  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(6'h0D, 5'd0, 5'd1, 16'h1234),   // 0  ori r1
    enc_i(6'h0D, 5'd0, 5'd2, 16'hFFFF),   // 4  ori r2 (zero ext)
    enc_r(5'd1, 5'd2, 5'd3, 6'h21),       // 8  addu r3
    enc_r(5'd1, 5'd2, 5'd4, 6'h23),       // 12 subu r4
    enc_i(6'h2B, 5'd0, 5'd3, 16'd8),      // 16 sw r3, 8(r0)
    enc_i(6'h23, 5'd0, 5'd5, 16'd8),      // 20 lw r5, 8(r0)
    enc_i(6'h0D, 5'd0, 5'd6, 16'd12),     // 24 ori r6, 12
    enc_i(6'h23, 5'd6, 5'd7, 16'hFFFC),   // 28 lw r7, -4(r6)
    enc_i(6'h04, 5'd5, 5'd7, 16'd2),      // 32 beq taken -> 44
    enc_i(6'h0D, 5'd0, 5'd8, 16'hDEAD),   // 36 shadow
    enc_i(6'h0D, 5'd0, 5'd8, 16'hDEAD),   // 40 shadow
    enc_i(6'h04, 5'd1, 5'd2, 16'd5),      // 44 beq not taken
    enc_r(5'd1, 5'd1, 5'd0, 6'h21),       // 48 addu r0
    enc_r(5'd0, 5'd0, 5'd9, 6'h21),       // 52 addu r9, r0, r0
    {6'h3F, 26'h0},                       // 56 unknown opcode
    enc_r(5'd2, 5'd1, 5'd10, 6'h23),      // 60 subu r10
    enc_i(6'h23, 5'd0, 5'd11, 16'd20),    // 64 lw r11, 20(r0) preloaded
    enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF)    // 68 beq to self
  };

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 17;
  localparam step_t STEPS [NSTEP] = '{
    '{32'd0,  1'b1, 5'd1,  32'h0000_1234, 4'd3},   // R3
    '{32'd4,  1'b1, 5'd2,  32'h0000_FFFF, 4'd3},   // R3 zero extension
    '{32'd8,  1'b1, 5'd3,  32'h0001_1233, 4'd2},   // R2 add
    '{32'd12, 1'b1, 5'd4,  32'hFFFF_1235, 4'd2},   // R2 subtract wraps
    '{32'd16, 1'b0, 5'd0,  32'h0,         4'd5},   // R5 store, no write
    '{32'd20, 1'b1, 5'd5,  32'h0001_1233, 4'd5},   // R5 reload
    '{32'd24, 1'b1, 5'd6,  32'd12,        4'd3},   // R3
    '{32'd28, 1'b1, 5'd7,  32'h0001_1233, 4'd4},   // R4 negative offset
    '{32'd32, 1'b0, 5'd0,  32'h0,         4'd6},   // R6 taken
    '{32'd44, 1'b0, 5'd0,  32'h0,         4'd6},   // R6 not taken
    '{32'd48, 1'b1, 5'd0,  32'h0000_2468, 4'd7},   // R7 write aimed at r0
    '{32'd52, 1'b1, 5'd9,  32'h0,         4'd7},   // R7 r0 still zero
    '{32'd56, 1'b0, 5'd0,  32'h0,         4'd8},   // R8 unknown opcode
    '{32'd60, 1'b1, 5'd10, 32'h0000_EDCB, 4'd2},   // R2
    '{32'd64, 1'b1, 5'd11, 32'hCAFE_F00D, 4'd10},  // R10 preloaded data
    '{32'd68, 1'b0, 5'd0,  32'h0,         4'd6},   // R6 backward branch
    '{32'd68, 1'b0, 5'd0,  32'h0,         4'd6}    // R6 self loop holds
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    load_en = 1'b0; load_sel = 1'b0; load_addr = '0; load_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", dbg_pc, 32'd0);
    chk("R1", "wr_en in reset", {31'd0, dbg_wr_en}, 32'd0);

    // R10: preload both stores while reset is held
    for (int i = 0; i < NPROG; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_sel = 1'b0; load_addr = AW'(i); load_data = PROG[i];
    end
    @(negedge clk);
    load_sel = 1'b1; load_addr = AW'(5); load_data = 32'hCAFE_F00D;
    @(negedge clk);
    load_en = 1'b0;

    // Release; core runs from the second rising edge on (R1)
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "pc while synchronising", dbg_pc, 32'd0);
    chk("R1", "wr_en while synchronising", {31'd0, dbg_wr_en}, 32'd0);
    @(posedge clk);

    // Vector table: one row per executed cycle (R9 for the PC trace)
    for (int k = 0; k < NSTEP; k++) begin
      @(negedge clk);
      chk("R9", $sformatf("pc step %0d", k), dbg_pc, STEPS[k].pc);
      chk($sformatf("R%0d", STEPS[k].req), $sformatf("wr_en step %0d", k),
          {31'd0, dbg_wr_en}, {31'd0, STEPS[k].we});
      if (STEPS[k].we) begin
        chk($sformatf("R%0d", STEPS[k].req), $sformatf("wr_addr step %0d", k),
            {27'd0, dbg_wr_addr}, {27'd0, STEPS[k].wa});
        chk($sformatf("R%0d", STEPS[k].req), $sformatf("wr_data step %0d", k),
            dbg_wr_data, STEPS[k].wd);
      end
    end

    // R1: asynchronous reset mid-run clears PC with no clock edge
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "pc after async reset", dbg_pc, 32'd0);
    chk("R1", "wr_en after async reset", {31'd0, dbg_wr_en}, 32'd0);
    @(negedge clk);
    chk("R1", "pc held in reset", dbg_pc, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule